// File: doc/BRIEF.md
# Successive-Approximation Tuning Word Search with Tracking

This controller produces the tuning word of an on-chip numerically controlled oscillator whose output frequency is `fsw * fclk / 2^FSW_W`. The goal is to make that frequency match an unknown external frequency. An external frequency comparator reports one decision at a time: a valid strobe together with a bit that says whether the input runs faster than the oscillator.

After a start strobe, the controller runs a binary search. It begins at the middle of the usable range. On each decision it halves its step and moves the word up or down by that amount. When the step applied falls to one LSB, the search ends. From then on an up/down counter moves the word by one LSB per decision, so the oscillator keeps following the input.

The word never leaves the usable range of 0 to `2^FSW_W / 4`, which is a quarter of the clock rate.

Top module: `fsw_sar_tracker`

## Requirements
- R1: While reset is held, and until the first start strobe, `fsw_o` is 0 and `done_o` and `lock_o` are 0.
- R2: In the cycle after a start strobe, `fsw_o` equals 2^(FSW_W-3) (half the usable range) and `lock_o` is 0.
- R3: In search, each decision first halves the step. The step is 2^(FSW_W-3) right after start, so the first move is 2^(FSW_W-4). The word then rises by the halved step when `cmp_faster_i` is 1 and falls by it when `cmp_faster_i` is 0. After the search, `fsw_o` is within one LSB of any target reachable in range.
- R4: The word changes only in the cycle after `start_i` or `cmp_valid_i`. A `cmp_valid_i` seen before the first start has no effect, and each valid strobe moves the word at most once.
- R5: `done_o` is high for exactly one cycle. That cycle is the one after the decision that applies a step of one LSB, which is decision number FSW_W-3. `lock_o` rises in that same cycle.
- R6: While `lock_o` is high, each decision moves the word by exactly one LSB: up when `cmp_faster_i` is 1, down when it is 0.
- R7: The word never exceeds 2^(FSW_W-2) and never wraps below 0. Steps that would cross either limit stop at the limit.
- R8: A start strobe in any state restarts the search from the state given in R2. A start strobe wins over a decision presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin (or restart) a search |
| cmp_valid_i | input | 1 | Comparator decision strobe |
| cmp_faster_i | input | 1 | 1: input is faster than the oscillator; 0: slower |
| fsw_o | output | FSW_W | Oscillator tuning word |
| done_o | output | 1 | One-cycle pulse when the search completes |
| lock_o | output | 1 | High while tracking with the up/down counter |

## Verification
Several properties are checked on every cycle by the assertions. The word stays within the usable range. It holds steady when no start or decision arrives. A start always reloads the midpoint. The done pulse coincides with the rise of the lock flag, and each tracking decision moves the word by at most one LSB. Other behaviours can only be shown by the bench's scenarios, checked against a behavioural model. These are the halving step sequence, the convergence on a chosen target, the exact decision count that ends the search, and pinning at both range limits after searches driven only one way.

// File: rtl/fsw_sar_pkg.sv
package fsw_sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_TRACK  = 2'd2
  } sar_state_e;
endpackage

// File: rtl/fsw_rst_sync.sv
module fsw_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/fsw_step_gen.sv
module fsw_step_gen #(
  parameter int unsigned FSW_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  output logic [FSW_W-1:0] half_o,
  output logic             last_o
);
  localparam logic [FSW_W-1:0] STEP_INIT = FSW_W'(1) << (FSW_W - 3);

  logic [FSW_W-1:0] step_q, step_d;
  logic             step_en;

  assign half_o  = step_q >> 1;
  assign last_o  = (half_o == FSW_W'(1));
  assign step_en = load_i | shift_i;

  always_comb begin
    step_d = step_q;
    if (load_i)       step_d = STEP_INIT;
    else if (shift_i) step_d = half_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_q <= '0;
    else if (step_en) step_q <= step_d;
  end
endmodule

// File: rtl/fsw_sat_acc.sv
module fsw_sat_acc #(
  parameter int unsigned FSW_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             apply_i,
  input  logic             up_i,
  input  logic [FSW_W-1:0] delta_i,
  output logic [FSW_W-1:0] fsw_o
);
  localparam logic [FSW_W-1:0] FSW_INIT = FSW_W'(1) << (FSW_W - 3);
  localparam logic [FSW_W:0]   FSW_MAX  = (FSW_W+1)'(1) << (FSW_W - 2);

  logic [FSW_W-1:0] fsw_q, fsw_d;
  logic [FSW_W:0]   sum_w;
  logic             acc_en;

  assign sum_w  = {1'b0, fsw_q} + {1'b0, delta_i};
  assign acc_en = load_i | apply_i;

  always_comb begin
    fsw_d = fsw_q;
    if (load_i) begin
      fsw_d = FSW_INIT;
    end else if (apply_i) begin
      if (up_i) fsw_d = (sum_w > FSW_MAX) ? FSW_MAX[FSW_W-1:0] : sum_w[FSW_W-1:0];
      else      fsw_d = (delta_i > fsw_q) ? '0 : fsw_q - delta_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fsw_q <= '0;
    else if (acc_en) fsw_q <= fsw_d;
  end

  assign fsw_o = fsw_q;

  AST_FSW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, fsw_q} <= FSW_MAX); // R7
endmodule

// File: rtl/fsw_sar_tracker.sv
module fsw_sar_tracker
  import fsw_sar_pkg::*;
#(
  parameter int unsigned FSW_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_valid_i,
  input  logic             cmp_faster_i,
  output logic [FSW_W-1:0] fsw_o,
  output logic             done_o,
  output logic             lock_o
);
  localparam logic [FSW_W-1:0] FSW_INIT = FSW_W'(1) << (FSW_W - 3);

  logic             rst_n;
  sar_state_e       state_q, state_d;
  logic             done_q, done_d;
  logic             search_step, track_step, step_last;
  logic [FSW_W-1:0] step_half, delta;

  fsw_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  assign search_step = cmp_valid_i & ~start_i & (state_q == ST_SEARCH);
  assign track_step  = cmp_valid_i & ~start_i & (state_q == ST_TRACK);
  assign delta       = (state_q == ST_TRACK) ? FSW_W'(1) : step_half;

  fsw_step_gen #(.FSW_W(FSW_W)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (start_i),
    .shift_i (search_step),
    .half_o  (step_half),
    .last_o  (step_last)
  );

  fsw_sat_acc #(.FSW_W(FSW_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (start_i),
    .apply_i (search_step | track_step),
    .up_i    (cmp_faster_i),
    .delta_i (delta),
    .fsw_o   (fsw_o)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    if (start_i) begin
      state_d = ST_SEARCH;
    end else if (search_step && step_last) begin
      state_d = ST_TRACK;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;
  assign lock_o = (state_q == ST_TRACK);

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> (fsw_o == FSW_INIT) && !lock_o); // R8

  AST_HOLD_NO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!start_i && !cmp_valid_i) |=> $stable(fsw_o)); // R4

  AST_DONE_WITH_LOCK: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(lock_o) |-> done_o); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_TRACK_UNIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lock_o && cmp_valid_i && !start_i) |=>
      ((fsw_o == $past(fsw_o) + FSW_W'(1)) || (fsw_o + FSW_W'(1) == $past(fsw_o))
       || (fsw_o == $past(fsw_o)))); // R6
endmodule

// File: tb/fsw_sar_tracker_tb.sv
module fsw_sar_tracker_tb;
  localparam int    W        = 32;
  localparam time   CLK_HALF = 5ns;
  localparam longint INIT    = 64'd1 << (W - 3);
  localparam longint FMAX    = 64'd1 << (W - 2);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, valid = 1'b0, faster = 1'b0;
  logic [W-1:0] fsw;
  logic         done, lock;

  int    n_chk = 0, n_fail = 0, done_cnt = 0, cyc = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  longint m_fsw = 0, m_step = 0;
  int     m_state = 0;
  bit     m_done = 1'b0;

  always #CLK_HALF clk = ~clk;

  fsw_sar_tracker #(.FSW_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_valid_i(valid),
    .cmp_faster_i(faster), .fsw_o(fsw), .done_o(done), .lock_o(lock)
  );

  // behavioural reference
  always @(posedge clk) begin
    m_done <= 1'b0;
    if (!rst_n) begin
      m_fsw <= 0; m_step <= 0; m_state <= 0;
    end else if (start) begin
      m_fsw <= INIT; m_step <= INIT; m_state <= 1;
    end else if (valid && m_state == 1) begin
      longint h;
      h = m_step / 2;
      m_step <= h;
      m_fsw  <= faster ? m_fsw + h : m_fsw - h;
      if (h == 1) begin m_state <= 2; m_done <= 1'b1; end
    end else if (valid && m_state == 2) begin
      if (faster) m_fsw <= (m_fsw + 1 > FMAX) ? FMAX : m_fsw + 1;
      else        m_fsw <= (m_fsw == 0) ? 0 : m_fsw - 1;
    end
  end

  task automatic check(string req, longint act, longint exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (rst_n) begin
      check(cur_req, longint'(fsw), m_fsw, "fsw vs model");
      check(cur_req, longint'(done), longint'(m_done), "done vs model");
      check(cur_req, longint'(lock), longint'(m_state == 2), "lock vs model");
    end
  end

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic decide(bit f);
    @(negedge clk); valid = 1'b1; faster = f;
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic search_to(longint tgt, output int ndec);
    ndec = 0;
    while (!lock && ndec < 64) begin
      decide(tgt > m_fsw);
      ndec++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int nd;
    longint tgt;
    repeat (3) @(negedge clk);
    check("R1", longint'(fsw), 0, "fsw in reset");
    check("R1", longint'(lock), 0, "lock in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", longint'(done), 0, "done after reset");

    cur_req = "R4";
    decide(1'b1); decide(1'b0);
    @(negedge clk);
    check("R4", longint'(fsw), 0, "valid before start ignored");

    cur_req = "R2";
    do_start();
    check("R2", longint'(fsw), INIT, "midpoint after start");
    check("R2", longint'(lock), 0, "lock after start");

    cur_req = "R3";
    decide(1'b1);
    check("R3", longint'(fsw), INIT + (INIT / 2), "first step up");
    decide(1'b0);
    check("R3", longint'(fsw), INIT + (INIT / 2) - (INIT / 4), "second step down");
    repeat (3) @(negedge clk);
    check("R4", longint'(fsw), INIT + (INIT / 2) - (INIT / 4), "hold without decision");

    cur_req = "R5";
    do_start();
    done_cnt = 0;
    tgt = 64'd123456789;
    search_to(tgt, nd);
    check("R5", nd, W - 3, "decisions to end search");
    check("R5", done_cnt, 1, "done pulse count");
    check("R3", longint'((longint'(fsw) - tgt <= 1 && tgt - longint'(fsw) <= 1)), 1, "converged within 1 LSB");

    cur_req = "R6";
    tgt = longint'(fsw);
    repeat (5) decide(1'b1);
    check("R6", longint'(fsw), tgt + 5, "track up 5");
    repeat (2) decide(1'b0);
    check("R6", longint'(fsw), tgt + 3, "track down 2");
    check("R6", longint'(lock), 1, "lock held while tracking");

    cur_req = "R7";
    do_start();
    search_to(FMAX, nd);
    check("R7", longint'(fsw), FMAX - 1, "all-up search end");
    repeat (3) decide(1'b1);
    check("R7", longint'(fsw), FMAX, "saturate at top");
    do_start();
    search_to(0, nd);
    check("R7", longint'(fsw), 1, "all-down search end");
    repeat (3) decide(1'b0);
    check("R7", longint'(fsw), 0, "saturate at zero");

    cur_req = "R8";
    do_start();
    decide(1'b1); decide(1'b1);
    @(negedge clk); start = 1'b1; valid = 1'b1; faster = 1'b1;
    @(negedge clk); start = 1'b0; valid = 1'b0;
    check("R8", longint'(fsw), INIT, "restart wins over decision");
    check("R8", longint'(lock), 0, "restart clears lock");
    decide(1'b0);
    check("R8", longint'(fsw), INIT - INIT / 2, "step reloaded on restart");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule